// File: doc/BRIEF.md
# Receive and Transmit Frame Statistics Counter Bank

This block keeps per-frame statistics for an Ethernet MAC. The MAC datapath presents one status strobe per finished frame. The strobe carries the frame direction, its length in bytes, a CRC-error flag, an address class (unicast, multicast, broadcast or none) and a pause-frame flag. The block turns each strobe into increments of a bank of saturating counters. The bank holds good-frame counts per direction, a receive CRC-error count, receive address-class counts, four length-fault counts and a seven-bin receive length histogram. It also keeps two 64-bit octet totals.

Software reads the counters through a registered 32-bit read port. A 16-bit maximum-frame-length input sets the oversize and jabber limit and the upper edge of the top histogram bin. The usual value for this input is 1518. A synchronous clear input zeroes every counter and both holding registers.

Each 64-bit octet total is read as two words, low word first. Reading the low word captures the upper word of the same counter into a holding register. The next high-word read returns that captured value, so the two halves always belong to one sample of the counter.

Top module: `rmon_stat_bank`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, every counter word and both octet holding registers read 0, and `rd_valid` is 0 after reset.
- R2: A frame strobe in the same cycle as `clear` changes no counter.
- R3: Receive frames without CRC error (pause frames included) increment address 0, and transmit frames without CRC error increment address 1. Receive frames with a CRC error increment address 2.
- R4: Error-free receive frames increment an address-class counter chosen by `frm_cast`: 0 unicast at address 3, 1 multicast at address 4, 2 broadcast at address 5, 3 none. A multicast frame with `frm_pause` set does not increment address 4.
- R5: A receive frame shorter than 64 bytes increments undersize (address 6) when it has no CRC error, and fragment (address 8) when it has one.
- R6: A receive frame longer than `max_len` increments oversize (address 7) when it has no CRC error, and jabber (address 9) when it has one.
- R7: Every receive frame, good or errored, increments at most one histogram bin. The bins are: address 10 for exactly 64 bytes, 11 for 65–127, 12 for 128–255, 13 for 256–511, 14 for 512–1023, 15 for 1024–1518, and 16 for 1519 up to and including `max_len`. Transmit frames touch no bin.
- R8: The receive octet total adds the length of every receive frame. The transmit octet total adds the length of every error-free transmit frame. The receive total is read at addresses 17 (low) and 18 (high), and the transmit total at 19 (low) and 20 (high).
- R9: A read of address 17 or 19 captures bits 63:32 of that counter. The next read of address 18 or 20 returns the captured value, even if the counter has moved on since.
- R10: Counters saturate at their all-ones value and never wrap to zero.
- R11: `rd_valid` and `rd_data` appear one cycle after a cycle with `rd_en` high. Frame counters are zero-extended to 32 bits, and an address above 20 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all statistics |
| max_len | input | 16 | Programmed maximum frame length in bytes |
| frm_valid | input | 1 | Frame status strobe |
| frm_tx | input | 1 | 1 for a transmit frame, 0 for a receive frame |
| frm_len | input | 16 | Frame length in bytes |
| frm_crc_err | input | 1 | Frame has a CRC error |
| frm_cast | input | 2 | Address class: 0 unicast, 1 multicast, 2 broadcast, 3 none |
| frm_pause | input | 1 | Frame is a pause frame |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
A wrong classification decision shows up only when the affected counter is read back, so the bench compares every address against a reference model after each stimulus phase. This bounds the detection delay to one phase of traffic. A fault in the saturation or clear path is exposed by saturating counters built with an 8-bit width, and by clearing in the same cycle as a strobe. A fault in the snapshot path shows as a high word that differs from the value captured at the low read. The bench reads the low word while the upper half of the counter is still 0, then carries the counter past 2^32 before reading the high word.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
    localparam int NUM_CTR   = 17;
    localparam int RD_ADDR_W = 5;

    localparam int C_RX_GOOD = 0;
    localparam int C_TX_GOOD = 1;
    localparam int C_RX_CRC  = 2;
    localparam int C_UCAST   = 3;
    localparam int C_MCAST   = 4;
    localparam int C_BCAST   = 5;
    localparam int C_UNDER   = 6;
    localparam int C_OVER    = 7;
    localparam int C_FRAG    = 8;
    localparam int C_JABBER  = 9;
    localparam int C_BIN0    = 10;
    localparam int NUM_BINS  = 7;

    localparam int A_RXO_LO = 17;
    localparam int A_RXO_HI = 18;
    localparam int A_TXO_LO = 19;
    localparam int A_TXO_HI = 20;

    localparam int MIN_LEN  = 64;
    localparam int TOP_BIN_LO = 1519;

    typedef enum logic [1:0] {
        CAST_UNI   = 2'd0,
        CAST_MULTI = 2'd1,
        CAST_BROAD = 2'd2,
        CAST_NONE  = 2'd3
    } cast_e;

    function automatic int unsigned bin_lo(int b);
        case (b)
            0: return 64;
            1: return 65;
            2: return 128;
            3: return 256;
            4: return 512;
            default: return 1024;
        endcase
    endfunction

    function automatic int unsigned bin_hi(int b);
        case (b)
            0: return 64;
            1: return 127;
            2: return 255;
            3: return 511;
            4: return 1023;
            default: return 1518;
        endcase
    endfunction
endpackage

// File: rtl/rmon_classify.sv
module rmon_classify
    import rmon_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 frm_valid,
    input  logic                 frm_tx,
    input  logic [LEN_W-1:0]     frm_len,
    input  logic                 frm_crc_err,
    input  logic [1:0]           frm_cast,
    input  logic                 frm_pause,
    input  logic [LEN_W-1:0]     max_len,
    output logic [NUM_CTR-1:0]   inc,
    output logic                 rx_oct_add,
    output logic                 tx_oct_add
);
    logic take, rx, tx, good, short_f, long_f;
    logic [NUM_BINS-1:0] bin_hit;

    always_comb begin
        take    = frm_valid & ~clear;
        rx      = take & ~frm_tx;
        tx      = take & frm_tx;
        good    = ~frm_crc_err;
        short_f = frm_len < LEN_W'(MIN_LEN);
        long_f  = frm_len > max_len;
    end

    for (genvar b = 0; b < NUM_BINS - 1; b++) begin : g_fixed_bin
        localparam logic [LEN_W-1:0] LO = LEN_W'(bin_lo(b));
        localparam logic [LEN_W-1:0] HI = LEN_W'(bin_hi(b));
        assign bin_hit[b] = rx && (frm_len >= LO) && (frm_len <= HI);
    end
    assign bin_hit[NUM_BINS-1] = rx && (frm_len >= LEN_W'(TOP_BIN_LO)) && (frm_len <= max_len);

    always_comb begin
        inc            = '0;
        inc[C_RX_GOOD] = rx & good;
        inc[C_TX_GOOD] = tx & good;
        inc[C_RX_CRC]  = rx & ~good;
        inc[C_UCAST]   = rx & good & (frm_cast == CAST_UNI);
        inc[C_MCAST]   = rx & good & (frm_cast == CAST_MULTI) & ~frm_pause;
        inc[C_BCAST]   = rx & good & (frm_cast == CAST_BROAD);
        inc[C_UNDER]   = rx & good & short_f;
        inc[C_OVER]    = rx & good & long_f;
        inc[C_FRAG]    = rx & ~good & short_f;
        inc[C_JABBER]  = rx & ~good & long_f;
        inc[C_BIN0 +: NUM_BINS] = bin_hit;
        rx_oct_add     = rx;
        tx_oct_add     = tx & good;
    end

    // R5/R6: a length fault goes to exactly one of the good/errored counters
    assert_short_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc[C_UNDER], inc[C_FRAG], inc[C_OVER], inc[C_JABBER]}));
    assert_one_bin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc[C_BIN0 +: NUM_BINS]));
    assert_clear_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (inc == '0 && !rx_oct_add && !tx_oct_add));
endmodule

// File: rtl/rmon_counter_array.sv
module rmon_counter_array
    import rmon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OCT_W = 64,
    parameter int LEN_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic [NUM_CTR-1:0]              inc,
    input  logic                            rx_oct_add,
    input  logic                            tx_oct_add,
    input  logic [LEN_W-1:0]                frm_len,
    output logic [NUM_CTR-1:0][CNT_W-1:0]   cnt,
    output logic [OCT_W-1:0]                rx_oct,
    output logic [OCT_W-1:0]                tx_oct
);
    typedef struct packed {
        logic [NUM_CTR-1:0][CNT_W-1:0] cnt;
        logic [OCT_W-1:0]              rxo;
        logic [OCT_W-1:0]              txo;
    } state_t;

    state_t st_d, st_q;
    logic [OCT_W:0] rx_sum, tx_sum;

    always_comb begin
        st_d   = st_q;
        rx_sum = {1'b0, st_q.rxo} + (OCT_W+1)'(frm_len);
        tx_sum = {1'b0, st_q.txo} + (OCT_W+1)'(frm_len);
        if (clear) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < NUM_CTR; i++) begin
                if (inc[i] && (st_q.cnt[i] != '1))
                    st_d.cnt[i] = st_q.cnt[i] + CNT_W'(1);
            end
            if (rx_oct_add)
                st_d.rxo = rx_sum[OCT_W] ? '1 : rx_sum[OCT_W-1:0];
            if (tx_oct_add)
                st_d.txo = tx_sum[OCT_W] ? '1 : tx_sum[OCT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign rx_oct = st_q.rxo;
    assign tx_oct = st_q.txo;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0 && rx_oct == '0 && tx_oct == '0));
    assert_oct_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) |-> (rx_oct >= $past(rx_oct) && tx_oct >= $past(tx_oct)));
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(clear) |-> (cnt[i] >= $past(cnt[i])));
    end
endmodule

// File: rtl/rmon_read_port.sv
module rmon_read_port
    import rmon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OCT_W = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            rd_en,
    input  logic [RD_ADDR_W-1:0]            rd_addr,
    input  logic [NUM_CTR-1:0][CNT_W-1:0]   cnt,
    input  logic [OCT_W-1:0]                rx_oct,
    input  logic [OCT_W-1:0]                tx_oct,
    output logic [31:0]                     rd_data,
    output logic                            rd_valid
);
    localparam int HI_W = OCT_W - 32;

    typedef struct packed {
        logic [31:0] data;
        logic        valid;
        logic [31:0] rx_hold;
        logic [31:0] tx_hold;
    } rd_state_t;

    rd_state_t rs_d, rs_q;

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = rd_en;
        rs_d.data  = '0;
        if (rd_en) begin
            for (int i = 0; i < NUM_CTR; i++) begin
                if (rd_addr == RD_ADDR_W'(i)) rs_d.data = 32'(cnt[i]);
            end
            case (rd_addr)
                RD_ADDR_W'(A_RXO_LO): begin
                    rs_d.data    = rx_oct[31:0];
                    rs_d.rx_hold = 32'(rx_oct[OCT_W-1 -: HI_W]);
                end
                RD_ADDR_W'(A_RXO_HI): rs_d.data = rs_q.rx_hold;
                RD_ADDR_W'(A_TXO_LO): begin
                    rs_d.data    = tx_oct[31:0];
                    rs_d.tx_hold = 32'(tx_oct[OCT_W-1 -: HI_W]);
                end
                RD_ADDR_W'(A_TXO_HI): rs_d.data = rs_q.tx_hold;
                default: ;
            endcase
        end
        if (clear) begin
            rs_d.rx_hold = '0;
            rs_d.tx_hold = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_data  = rs_q.data;
    assign rd_valid = rs_q.valid;

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && (rd_addr == RD_ADDR_W'(A_RXO_LO))) && !clear |=> $stable(rs_q.rx_hold));
endmodule

// File: rtl/rmon_stat_bank.sv
module rmon_stat_bank
    import rmon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OCT_W = 64,
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [LEN_W-1:0]     max_len,
    input  logic                 frm_valid,
    input  logic                 frm_tx,
    input  logic [LEN_W-1:0]     frm_len,
    input  logic                 frm_crc_err,
    input  logic [1:0]           frm_cast,
    input  logic                 frm_pause,
    input  logic                 rd_en,
    input  logic [4:0]           rd_addr,
    output logic [31:0]          rd_data,
    output logic                 rd_valid
);
    logic [NUM_CTR-1:0]            inc;
    logic                          rx_oct_add, tx_oct_add;
    logic [NUM_CTR-1:0][CNT_W-1:0] cnt;
    logic [OCT_W-1:0]              rx_oct, tx_oct;

    rmon_classify #(.LEN_W(LEN_W)) i_classify (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .frm_valid(frm_valid), .frm_tx(frm_tx), .frm_len(frm_len),
        .frm_crc_err(frm_crc_err), .frm_cast(frm_cast), .frm_pause(frm_pause),
        .max_len(max_len), .inc(inc), .rx_oct_add(rx_oct_add), .tx_oct_add(tx_oct_add)
    );

    rmon_counter_array #(.CNT_W(CNT_W), .OCT_W(OCT_W), .LEN_W(LEN_W)) i_counters (
        .clk(clk), .rst_n(rst_n), .clear(clear), .inc(inc),
        .rx_oct_add(rx_oct_add), .tx_oct_add(tx_oct_add), .frm_len(frm_len),
        .cnt(cnt), .rx_oct(rx_oct), .tx_oct(tx_oct)
    );

    rmon_read_port #(.CNT_W(CNT_W), .OCT_W(OCT_W)) i_read (
        .clk(clk), .rst_n(rst_n), .clear(clear), .rd_en(rd_en), .rd_addr(rd_addr),
        .cnt(cnt), .rx_oct(rx_oct), .tx_oct(tx_oct),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/test_rmon_stat_bank.sv
module test_rmon_stat_bank;
    localparam int TB_CNT_W = 8;
    localparam int CMAX     = (1 << TB_CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic [15:0] max_len = 16'd1518;
    logic        frm_valid = 1'b0;
    logic        frm_tx = 1'b0;
    logic [15:0] frm_len = '0;
    logic        frm_crc_err = 1'b0;
    logic [1:0]  frm_cast = 2'd3;
    logic        frm_pause = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int unsigned exp_cnt [17];
    longint unsigned exp_rxo, exp_txo;

    always #2.5 clk = ~clk;

    rmon_stat_bank #(.CNT_W(TB_CNT_W)) i_rmon_stat_bank (
        .clk(clk), .rst_n(rst_n), .clear(clear), .max_len(max_len),
        .frm_valid(frm_valid), .frm_tx(frm_tx), .frm_len(frm_len),
        .frm_crc_err(frm_crc_err), .frm_cast(frm_cast), .frm_pause(frm_pause),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic string req_of(int a);
        if (a <= 2) return "R3";
        if (a <= 5) return "R4";
        if (a == 6 || a == 8) return "R5";
        if (a == 7 || a == 9) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, longint unsigned got, longint unsigned exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bump(int a);
        if (exp_cnt[a] < CMAX) exp_cnt[a]++;
    endtask

    task automatic model(bit tx, int len, bit err, int cast, bit pause);
        if (tx) begin
            if (!err) begin bump(1); exp_txo += len; end
            return;
        end
        exp_rxo += len;
        if (err) bump(2);
        else begin
            bump(0);
            if (cast == 0) bump(3);
            if (cast == 1 && !pause) bump(4);
            if (cast == 2) bump(5);
        end
        if (len < 64) bump(err ? 8 : 6);
        if (len > int'(max_len)) bump(err ? 9 : 7);
        if (len == 64) bump(10);
        else if (len >= 65 && len <= 127) bump(11);
        else if (len >= 128 && len <= 255) bump(12);
        else if (len >= 256 && len <= 511) bump(13);
        else if (len >= 512 && len <= 1023) bump(14);
        else if (len >= 1024 && len <= 1518) bump(15);
        else if (len >= 1519 && len <= int'(max_len)) bump(16);
    endtask

    task automatic model_clear();
        foreach (exp_cnt[i]) exp_cnt[i] = 0;
        exp_rxo = 0;
        exp_txo = 0;
    endtask

    task automatic send(bit tx, int len, bit err, int cast, bit pause, bit clr);
        @(negedge clk);
        frm_valid = 1'b1; frm_tx = tx; frm_len = 16'(len);
        frm_crc_err = err; frm_cast = 2'(cast); frm_pause = pause; clear = clr;
        if (clr) model_clear();
        else     model(tx, len, err, cast, pause);
    endtask

    task automatic idle();
        @(negedge clk);
        frm_valid = 1'b0; clear = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 5'(a);
        @(negedge clk);
        rd_en = 1'b0;
        check("R11", rd_valid, 1);
        d = rd_data;
    endtask

    task automatic check_all();
        logic [31:0] d, hi;
        for (int a = 0; a < 17; a++) begin
            rd(a, d);
            check(req_of(a), d, exp_cnt[a]);
        end
        rd(17, d); rd(18, hi);
        check("R8", {hi, d}, exp_rxo);
        rd(19, d); rd(20, hi);
        check("R8", {hi, d}, exp_txo);
    endtask

    function automatic int pick_len(int mx);
        int unsigned r = $urandom % 20;
        case (r)
            0: return 0;      1: return 63;    2: return 64;    3: return 65;
            4: return 127;    5: return 128;   6: return 255;   7: return 256;
            8: return 511;    9: return 512;   10: return 1023; 11: return 1024;
            12: return 1518;  13: return 1519; 14: return mx;   15: return mx + 1;
            default: return int'($urandom % 3000);
        endcase
    endfunction

    initial begin
        #(5.0 * 190000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        model_clear();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rd_valid, 0);
        check_all();                                   // R1 reset state

        // directed length and class corners, max_len = 1518
        send(0, 63, 0, 0, 0, 0);    // R5 undersize
        send(0, 63, 1, 0, 0, 0);    // R5 fragment
        send(0, 64, 0, 1, 1, 0);    // R4 pause multicast excluded
        send(0, 64, 0, 1, 0, 0);
        send(0, 1518, 0, 2, 0, 0);
        send(0, 1519, 0, 3, 0, 0);  // R6 oversize, no top bin
        send(0, 1600, 1, 0, 0, 0);  // R6 jabber
        send(1, 100, 0, 0, 0, 0);   // R3 tx good
        send(1, 200, 1, 0, 0, 0);   // tx errored: nothing
        idle();
        check_all();
        rd(25, d);
        check("R11", d, 0);

        // R2: strobe with clear is dropped, R1 clear zeroes
        send(0, 64, 0, 0, 0, 1);
        idle();
        check_all();

        // random traffic with a larger maximum, top bin reachable (R7)
        max_len = 16'd2000;
        for (int k = 0; k < 150; k++)
            send(1'($urandom % 4 == 0), pick_len(2000), 1'($urandom % 3 == 0),
                 int'($urandom % 4), 1'($urandom % 5 == 0), 0);
        idle();
        check_all();
        send(0, 0, 0, 0, 0, 1);
        idle();

        // R10 saturation
        for (int k = 0; k < 300; k++) send(0, 64, 0, 0, 0, 0);
        idle();
        check_all();
        send(0, 0, 0, 0, 0, 1);
        idle();

        // R8/R9 octet carry and snapshot
        for (int k = 0; k < 65536; k++) send(1, 65535, 0, 3, 0, 0);
        idle();
        rd(19, d);
        check("R8", d, 32'hFFFF0000);
        send(1, 65535, 0, 3, 0, 0);
        send(1, 65535, 0, 3, 0, 0);
        idle();
        rd(20, d);
        check("R9", d, 0);
        rd(19, d);
        check("R8", d, 32'h0000FFFE);
        rd(20, d);
        check("R9", d, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule